// File: doc/BRIEF.md
# Zero-Count Unit (Leading and Trailing)

This block counts the zero bits at one end of an operand for a processor execute stage. Each request carries an operand, a direction select (count from the least-significant end, or from the most-significant end) and a size select (the full 64-bit word, or only the low 32-bit half). The count comes back as a small unsigned integer, zero-extended to the operand width, after a fixed latency of two clock cycles. A new request can be issued on every cycle.

The datapath has no priority-encoder chain. In the first cycle the operand is optionally bit-reversed, so that a leading count becomes a trailing count, and then masked to the selected size. The lowest set bit is then isolated by ANDing the value with its two's-complement negation, and the resulting one-hot vector is registered. In the second cycle one wide OR reduction per index bit turns the one-hot vector into a binary bit number. A zero-operand override then replaces the index with the examined width.

Top module: `zero_count_unit`

## Requirements
- R1: With in_leading=0 and in_half=0, out_count equals the bit position of the least-significant 1 in the 64-bit operand.
- R2: With in_leading=1 and in_half=0, out_count equals 63 minus the bit position of the most-significant 1 in the 64-bit operand.
- R3: A request whose examined bits are all zero returns 64 when in_half=0.
- R4: With in_half=1 and in_leading=0, only operand bits 31..0 are examined, and out_count is the position of the lowest 1 among them. Bits 63..32 have no effect on the result.
- R5: With in_half=1 and in_leading=1, leading zeros are counted down from bit 31, so out_count is 31 minus the position of the highest 1 in bits 31..0. Bits 63..32 have no effect.
- R6: With in_half=1, a request whose low 32 bits are zero returns 32, whatever bits 63..32 hold.
- R7: out_valid is high for exactly one cycle, two clock cycles after each cycle in which in_valid is high, and is low otherwise.
- R8: Requests issued on consecutive cycles each produce their own result, in issue order, on consecutive cycles.
- R9: The result is zero-extended: out_count bits above bit 6 are always zero.
- R10: After synchronous reset, out_valid and out_count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; the other inputs are sampled in this cycle |
| in_operand | input | 64 | Value whose zeros are counted |
| in_leading | input | 1 | 1 counts from the most-significant end, 0 from the least-significant end |
| in_half | input | 1 | 1 examines only bits 31..0, 0 examines all 64 bits |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| out_count | output | 64 | Zero count, zero-extended |

## Verification
The in-line assertions watch, on every cycle, the properties that the pipeline structure must keep. The isolated vector holds at most one set bit and stays inside the low half in 32-bit mode. Each valid advances exactly one stage per cycle. A result never exceeds the examined width, and it is always zero-extended. Whether each count is numerically right can only be shown by the bench's scenarios: a sweep of single-bit and filled-from-a-position operands in all four modes, zero and upper-half-only operands, and random back-to-back traffic with idle gaps. These are compared against counts computed by scanning the operand in the bench.

// File: rtl/zcount_pkg.sv
package zcount_pkg;

  typedef enum logic [1:0] {
    ZC_TRAIL_FULL = 2'b00,
    ZC_LEAD_FULL  = 2'b01,
    ZC_TRAIL_HALF = 2'b10,
    ZC_LEAD_HALF  = 2'b11
  } zc_mode_e;

  function automatic zc_mode_e zc_mode(input logic half, input logic leading);
    return zc_mode_e'({half, leading});
  endfunction

endpackage

// File: rtl/zc_isolate_stage.sv
module zc_isolate_stage
  import zcount_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_operand,
  input  logic              in_leading,
  input  logic              in_half,
  output logic              s1_valid,
  output logic [DATA_W-1:0] s1_onehot,
  output logic              s1_half
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] rev_full;
  logic [HALF_W-1:0] rev_low;
  logic [DATA_W-1:0] prepped;
  logic [DATA_W-1:0] lowest;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev_full
      assign rev_full[i] = in_operand[DATA_W-1-i];
    end
    for (genvar j = 0; j < HALF_W; j++) begin : g_rev_low
      assign rev_low[j] = in_operand[HALF_W-1-j];
    end
  endgenerate

  always_comb begin
    unique case (zc_mode(in_half, in_leading))
      ZC_TRAIL_FULL: prepped = in_operand;
      ZC_LEAD_FULL:  prepped = rev_full;
      ZC_TRAIL_HALF: prepped = {{HALF_W{1'b0}}, in_operand[HALF_W-1:0]};
      ZC_LEAD_HALF:  prepped = {{HALF_W{1'b0}}, rev_low};
      default:       prepped = in_operand;
    endcase
  end

  assign lowest = prepped & (~prepped + {{(DATA_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_onehot <= '0;
      s1_half   <= 1'b0;
    end else begin
      s1_valid  <= in_valid;
      s1_onehot <= lowest;
      s1_half   <= in_half;
    end
  end

  assert_onehot_isolate_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s1_onehot));

  assert_half_mask_R4: assert property (@(posedge clk) disable iff (rst)
    s1_half |-> (s1_onehot[DATA_W-1:HALF_W] == '0));

  assert_stage1_advance_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (s1_valid == $past(in_valid)));

endmodule

// File: rtl/zc_onehot_enc.sv
module zc_onehot_enc #(
  parameter int W     = 64,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     onehot,
  output logic [IDX_W-1:0] index
);

  generate
    for (genvar b = 0; b < IDX_W; b++) begin : g_bit
      logic [W-1:0] sel;
      for (genvar i = 0; i < W; i++) begin : g_pos
        assign sel[i] = ((i >> b) & 1) != 0;
      end
      assign index[b] = |(onehot & sel);
    end
  endgenerate

endmodule

// File: rtl/zero_count_unit.sv
module zero_count_unit #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_operand,
  input  logic              in_leading,
  input  logic              in_half,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_count
);

  localparam int IDX_W  = $clog2(DATA_W);
  localparam int CNT_W  = IDX_W + 1;
  localparam int HALF_W = DATA_W / 2;

  logic              s1_valid;
  logic [DATA_W-1:0] s1_onehot;
  logic              s1_half;
  logic [IDX_W-1:0]  enc_index;
  logic              s1_zero;
  logic [CNT_W-1:0]  count_next;

  zc_isolate_stage #(.DATA_W(DATA_W)) u_stage1 (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_operand (in_operand),
    .in_leading (in_leading),
    .in_half    (in_half),
    .s1_valid   (s1_valid),
    .s1_onehot  (s1_onehot),
    .s1_half    (s1_half)
  );

  zc_onehot_enc #(.W(DATA_W), .IDX_W(IDX_W)) u_enc (
    .onehot (s1_onehot),
    .index  (enc_index)
  );

  assign s1_zero = ~|s1_onehot;

  always_comb begin
    if (s1_zero)
      count_next = s1_half ? CNT_W'(HALF_W) : CNT_W'(DATA_W);
    else
      count_next = {1'b0, enc_index};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_count <= '0;
    end else begin
      out_valid <= s1_valid;
      out_count <= {{(DATA_W-CNT_W){1'b0}}, count_next};
    end
  end

  assert_stage2_advance_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(s1_valid)));

  assert_zero_extend_R9: assert property (@(posedge clk) disable iff (rst)
    out_count[DATA_W-1:CNT_W] == '0);

  assert_full_bound_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_count <= DATA_W));

  assert_half_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(s1_valid) && $past(s1_half)) |-> (out_count <= HALF_W));

endmodule

// File: tb/zero_count_unit_test.sv
module zero_count_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 64;
  localparam int H = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_operand = '0;
  logic         in_leading = 1'b0;
  logic         in_half = 1'b0;
  logic         out_valid;
  logic [W-1:0] out_count;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic   exp_v [2];
  int     exp_c [2];
  string  exp_t [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  zero_count_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
    .in_leading(in_leading), .in_half(in_half),
    .out_valid(out_valid), .out_count(out_count)
  );

  function automatic int ref_count(input logic [W-1:0] x, input logic lead, input logic half);
    int n = half ? H : W;
    if (!lead) begin
      for (int i = 0; i < n; i++) if (x[i]) return i;
    end else begin
      for (int i = n-1; i >= 0; i--) if (x[i]) return n-1-i;
    end
    return n;
  endfunction

  function automatic string ref_tag(input logic [W-1:0] x, input logic lead, input logic half);
    if (half) begin
      if (x[H-1:0] == '0) return "R6";
      return lead ? "R5" : "R4";
    end
    if (x == '0) return "R3";
    return lead ? "R2" : "R1";
  endfunction

  task automatic check_out();
    total++;
    if (out_valid !== exp_v[1]) begin
      bad++;
      $display("FAIL R7 out_valid actual=%0b expected=%0b", out_valid, exp_v[1]);
    end
    if (exp_v[1]) begin
      total++;
      if (out_count !== W'(exp_c[1])) begin
        bad++;
        $display("FAIL %s out_count actual=%0d expected=%0d", exp_t[1], out_count, exp_c[1]);
      end
      total++;
      if (out_count[W-1:7] !== '0) begin
        bad++;
        $display("FAIL R9 upper bits actual=%h expected=0", out_count[W-1:7]);
      end
    end
  endtask

  // One cycle: check the result due now, then drive the next request (R8: back-to-back)
  task automatic step(input logic v, input logic [W-1:0] x, input logic lead, input logic half);
    @(negedge clk);
    check_out();
    exp_v[1] = exp_v[0];
    exp_c[1] = exp_c[0];
    exp_t[1] = exp_t[0];
    exp_v[0] = v;
    exp_c[0] = ref_count(x, lead, half);
    exp_t[0] = ref_tag(x, lead, half);
    in_valid   = v;
    in_operand = x;
    in_leading = lead;
    in_half    = half;
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    exp_v[0] = 0; exp_v[1] = 0;
    exp_c[0] = 0; exp_c[1] = 0;
    exp_t[0] = "R7"; exp_t[1] = "R7";
    in_valid = 1'b1;
    in_operand = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || out_count !== '0) begin
      bad++;
      $display("FAIL R10 reset actual=%0b/%0d expected=0/0", out_valid, out_count);
    end
    in_valid = 1'b0;
    rst = 1'b0;

    // R1 R2 R4 R5: single set bit and filled-from-position, all four modes, back-to-back
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < W; i++) begin
        step(1'b1, W'(1) << i, m[0], m[1]);
        step(1'b1, ~W'(0) << i, m[0], m[1]);
        step(1'b1, ~W'(0) >> i, m[0], m[1]);
      end
    end

    // R3 R6: zero examined bits; R4 R5: upper half must be ignored
    for (int m = 0; m < 4; m++) begin
      step(1'b1, '0, m[0], m[1]);
      step(1'b1, {32'hFFFF_FFFF, 32'h0}, m[0], m[1]);
      step(1'b1, {32'hA5A5_0001, 32'h0001_0000}, m[0], m[1]);
      step(1'b1, {32'h8000_0000, 32'h8000_0001}, m[0], m[1]);
    end

    // R7 R8: random traffic with idle gaps
    for (int k = 0; k < 2000; k++) begin
      logic [W-1:0] x;
      logic [W-1:0] mask;
      x = {$urandom, $urandom};
      mask = ~W'(0) << ($urandom % W);
      if ($urandom % 2 == 0) x = x & mask;
      else x = x & ~mask;
      step(($urandom % 4) != 0, x, $urandom % 2, $urandom % 2);
    end

    // drain: R7 requires out_valid low afterwards
    for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b0, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule